// File: doc/BRIEF.md
# Configurable Ternary Selector Cell

This block is a behavioural digital model of one configurable logic cell that computes on trits, each carried as a 2-bit code. The cell holds three 3-to-1 ternary selectors. Each data slot of each selector is set to a constant or to a routed line trit. A per-selector control trit picks the slot. A selector can also be collapsed into one of two binary threshold modes. The outer selectors can be chained into the middle one, so that one control trit steers the results of the other two.

A feedback setting turns the middle selector into a transparent ternary latch. In that mode it follows the result of the first selector while its control trit is P, and it keeps its last value otherwise. An auxiliary output can tap any one of the three selector results, or it can be left unconnected.

The cell is used inside a larger fabric model. The fabric supplies four configuration bytes, nine routed line trits and three control trits, and it collects three result trits and the auxiliary trit. The only storage is the latch value. All other paths are combinational.

Top module: `tern_cell`

## Requirements
- R1: Trits are encoded as N=2'b10, O=2'b00 and P=2'b01. If any of the nine line trits or three control trits is 2'b11, every result trit and the AUX trit read O, and the latch value is not updated on that clock edge.
- R2: Each selector byte holds three 2-bit slot source codes: bits [1:0] for the N slot, [3:2] for the O slot and [5:4] for the P slot. Code 00 gives constant O, 01 gives constant P, 10 gives constant N, and 11 passes the routed line trit for that slot. Selector k slot j uses line_i bits [6k+2j+1:6k+2j], with k and j counted from 0.
- R3: With bits 6 and 7 of its byte clear, a selector outputs its N, O or P slot when its control trit (ctl_i bits [2k+1:2k]) is N, O or P respectively.
- R4: With bit 6 set and bit 7 clear, a control of N or O selects the N slot and a control of P selects the P slot.
- R5: With bit 7 set, a control of N selects the N slot and a control of O or P selects the P slot. This holds whatever the value of bit 6.
- R6: When cfg_ext bit 4 is clear, the N slot of selector 2 takes the result of selector 1 instead of its own configured source. When cfg_ext bit 5 is clear, the P slot of selector 2 takes the result of selector 3. When a bit is set, the slot uses its own configured source.
- R7: cfg_ext bits [7:6] choose the AUX source: 00 none, 01 selector 1, 10 selector 2, 11 selector 3. aux_vld_o is high exactly when the field is nonzero, and with 00 the AUX trit reads O.
- R8: With cfg_ext bit 0 set and control trit 2 equal to P, result 2 equals result 1 in the same cycle.
- R9: With cfg_ext bit 0 set and control trit 2 not P, result 2 shows the value that result 2 had at the last clock edge taken in latch mode with legal inputs. After reset this value is O.
- R10: No result trit and no AUX trit ever carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the latch value |
| rst_n | input | 1 | Asynchronous active-low reset; clears the latch value to O |
| cfg_s1 | input | 8 | Configuration byte of selector 1 |
| cfg_s2 | input | 8 | Configuration byte of selector 2 |
| cfg_s3 | input | 8 | Configuration byte of selector 3 |
| cfg_ext | input | 8 | Feedback, chaining and AUX source settings |
| line_i | input | 18 | Nine routed line trits, three per selector |
| ctl_i | input | 6 | Three control trits, one per selector |
| res_o | output | 6 | Three selector result trits |
| aux_o | output | 2 | Auxiliary trit |
| aux_vld_o | output | 1 | AUX source is connected |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that the latch-hold check applies only after a cycle in which latch mode was active with legal inputs and reset was released. The illegal-code check takes the 2'b11 pattern as the only invalid code on any line or control trit. The stimulus changes inputs only on falling edges. It draws trits mostly from the three legal codes and injects 2'b11 about once in twenty trits, so that both the masked and the normal behaviour are covered. Random configuration bytes cover all four selector modes, the chaining bits and the feedback bit.

// File: rtl/tern_pkg.sv
package tern_pkg;
    localparam int TW    = 2;
    localparam int NSEL  = 3;
    localparam int NSLOT = 3;
    localparam int CFGW  = 8;
    localparam int NLINE = NSEL * NSLOT;

    typedef logic [TW-1:0] trit_t;

    localparam trit_t T_O   = 2'b00;
    localparam trit_t T_P   = 2'b01;
    localparam trit_t T_N   = 2'b10;
    localparam trit_t T_BAD = 2'b11;

    typedef enum logic [1:0] {SM_TERN, SM_XXY, SM_XYY} sel_mode_e;
    typedef enum logic [1:0] {MEM_OFF, MEM_OPEN, MEM_HOLD} mem_state_e;
endpackage

// File: rtl/tern_src.sv
module tern_src
    import tern_pkg::*;
(
    input  logic [1:0] code,
    input  trit_t      routed,
    output trit_t      val
);
    always_comb begin
        unique case (code)
            2'b00:   val = T_O;
            2'b01:   val = T_P;
            2'b10:   val = T_N;
            default: val = routed;
        endcase
    end
endmodule

// File: rtl/tern_sel.sv
module tern_sel
    import tern_pkg::*;
(
    input  trit_t slot_n,
    input  trit_t slot_o,
    input  trit_t slot_p,
    input  trit_t ctl,
    input  logic  xxy_en,
    input  logic  xyy_en,
    output trit_t y
);
    sel_mode_e mode;

    always_comb begin
        if (xyy_en)      mode = SM_XYY;
        else if (xxy_en) mode = SM_XXY;
        else             mode = SM_TERN;
    end

    always_comb begin
        unique case (mode)
            SM_XXY:  y = (ctl == T_P) ? slot_p : slot_n;
            SM_XYY:  y = (ctl == T_N) ? slot_n : slot_p;
            default: begin
                if (ctl == T_N)      y = slot_n;
                else if (ctl == T_P) y = slot_p;
                else                 y = slot_o;
            end
        endcase
    end
endmodule

// File: rtl/tern_mem.sv
module tern_mem
    import tern_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fb_en,
    input  logic  legal,
    input  trit_t ctl,
    input  trit_t d,
    output trit_t q
);
    mem_state_e st;
    trit_t      held;

    always_comb begin
        if (!fb_en)          st = MEM_OFF;
        else if (ctl == T_P) st = MEM_OPEN;
        else                 st = MEM_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= T_O;
        end else if (legal) begin
            unique case (st)
                MEM_OPEN: held <= d;
                MEM_HOLD: held <= held;
                default:  held <= held;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            MEM_OPEN: q = d;
            default:  q = held;
        endcase
    end
endmodule

// File: rtl/tern_cell.sv
module tern_cell
    import tern_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFGW-1:0]      cfg_s1,
    input  logic [CFGW-1:0]      cfg_s2,
    input  logic [CFGW-1:0]      cfg_s3,
    input  logic [CFGW-1:0]      cfg_ext,
    input  logic [NLINE*TW-1:0]  line_i,
    input  logic [NSEL*TW-1:0]   ctl_i,
    output logic [NSEL*TW-1:0]   res_o,
    output logic [TW-1:0]        aux_o,
    output logic                 aux_vld_o
);
    localparam int FB_BIT   = 0;
    localparam int IND1_BIT = 4;
    localparam int IND3_BIT = 5;
    localparam int AUX_LSB  = 6;

    logic [CFGW-1:0] scfg [NSEL];
    trit_t           src  [NLINE];
    trit_t           y1, y2_mux, y2, y3;
    trit_t           s2_n, s2_p, aux_raw;
    logic            legal;

    assign scfg[0] = cfg_s1;
    assign scfg[1] = cfg_s2;
    assign scfg[2] = cfg_s3;

    for (genvar k = 0; k < NSEL; k++) begin : g_sel
        for (genvar j = 0; j < NSLOT; j++) begin : g_slot
            tern_src u_src (
                .code   (scfg[k][2*j +: 2]),
                .routed (line_i[TW*(NSLOT*k+j) +: TW]),
                .val    (src[NSLOT*k+j])
            );
        end
    end

    always_comb begin
        legal = 1'b1;
        for (int i = 0; i < NLINE; i++)
            if (line_i[TW*i +: TW] == T_BAD) legal = 1'b0;
        for (int i = 0; i < NSEL; i++)
            if (ctl_i[TW*i +: TW] == T_BAD) legal = 1'b0;
    end

    tern_sel u_sel1 (
        .slot_n (src[0]), .slot_o (src[1]), .slot_p (src[2]),
        .ctl    (ctl_i[1:0]),
        .xxy_en (cfg_s1[6]), .xyy_en (cfg_s1[7]),
        .y      (y1)
    );

    tern_sel u_sel3 (
        .slot_n (src[6]), .slot_o (src[7]), .slot_p (src[8]),
        .ctl    (ctl_i[5:4]),
        .xxy_en (cfg_s3[6]), .xyy_en (cfg_s3[7]),
        .y      (y3)
    );

    assign s2_n = cfg_ext[IND1_BIT] ? src[3] : y1;
    assign s2_p = cfg_ext[IND3_BIT] ? src[5] : y3;

    tern_sel u_sel2 (
        .slot_n (s2_n), .slot_o (src[4]), .slot_p (s2_p),
        .ctl    (ctl_i[3:2]),
        .xxy_en (cfg_s2[6]), .xyy_en (cfg_s2[7]),
        .y      (y2_mux)
    );

    trit_t mem_q;
    tern_mem u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .fb_en (cfg_ext[FB_BIT]),
        .legal (legal),
        .ctl   (ctl_i[3:2]),
        .d     (y1),
        .q     (mem_q)
    );

    assign y2 = cfg_ext[FB_BIT] ? mem_q : y2_mux;

    always_comb begin
        unique case (cfg_ext[AUX_LSB +: 2])
            2'b01:   aux_raw = y1;
            2'b10:   aux_raw = y2;
            2'b11:   aux_raw = y3;
            default: aux_raw = T_O;
        endcase
    end

    assign aux_vld_o = (cfg_ext[AUX_LSB +: 2] != 2'b00);
    assign aux_o     = legal ? aux_raw : T_O;
    assign res_o     = legal ? {y3, y2, y1} : {NSEL{T_O}};
endmodule

// File: rtl/tern_cell_chk.sv
module tern_cell_chk
    import tern_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [CFGW-1:0]     cfg_ext,
    input logic [NLINE*TW-1:0] line_i,
    input logic [NSEL*TW-1:0]  ctl_i,
    input logic [NSEL*TW-1:0]  res_o,
    input logic [TW-1:0]       aux_o,
    input logic                aux_vld_o
);
    logic ok;
    always_comb begin
        ok = 1'b1;
        for (int i = 0; i < NLINE; i++)
            if (line_i[TW*i +: TW] == T_BAD) ok = 1'b0;
        for (int i = 0; i < NSEL; i++)
            if (ctl_i[TW*i +: TW] == T_BAD) ok = 1'b0;
    end

    a_r1_bad_code_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |-> (res_o == '0 && aux_o == T_O));

    a_r7_unconnected_aux: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_vld_o |-> aux_o == T_O);

    a_r7_aux_tap1: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_vld_o && cfg_ext[7:6] == 2'b01) |-> aux_o == res_o[1:0]);

    a_r8_latch_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext[0] && ok && ctl_i[3:2] == T_P) |-> res_o[3:2] == res_o[1:0]);

    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext[0] && ok && ctl_i[3:2] != T_P && $past(rst_n)
         && $past(cfg_ext[0]) && $past(ok)) |-> res_o[3:2] == $past(res_o[3:2]));

    a_r10_no_bad_out: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o[1:0] != T_BAD && res_o[3:2] != T_BAD && res_o[5:4] != T_BAD
         && aux_o != T_BAD));
endmodule

bind tern_cell tern_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ext   (cfg_ext),
    .line_i    (line_i),
    .ctl_i     (ctl_i),
    .res_o     (res_o),
    .aux_o     (aux_o),
    .aux_vld_o (aux_vld_o)
);

// File: tb/sim_tern_cell.sv
module sim_tern_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_s1 = '0, cfg_s2 = '0, cfg_s3 = '0, cfg_ext = '0;
    logic [17:0] line_i = '0;
    logic [5:0]  ctl_i = '0;
    logic [5:0]  res_o;
    logic [1:0]  aux_o;
    logic        aux_vld_o;

    int tests = 0, fails = 0;
    logic done = 1'b0;
    logic [1:0] m_held = 2'b00;

    always #5 clk = ~clk;

    tern_cell u0 (.*);

    function automatic logic [1:0] bsrc(input logic [1:0] c, input logic [1:0] r);
        if (c == 2'b00) return 2'b00;
        if (c == 2'b01) return 2'b01;
        if (c == 2'b10) return 2'b10;
        return r;
    endfunction

    function automatic logic [1:0] bsel(input logic [7:0] c, input logic [1:0] n,
                                        input logic [1:0] o, input logic [1:0] p,
                                        input logic [1:0] t);
        if (c[7]) return (t == 2'b10) ? n : p;
        if (c[6]) return (t == 2'b01) ? p : n;
        case (t)
            2'b10:   return n;
            2'b01:   return p;
            default: return o;
        endcase
    endfunction

    logic [1:0] e1, e2, e3, eaux;
    logic       elegal, evld;

    task automatic model();
        logic [1:0] n2, p2;
        elegal = 1'b1;
        for (int i = 0; i < 9; i++) if (line_i[2*i +: 2] == 2'b11) elegal = 1'b0;
        for (int i = 0; i < 3; i++) if (ctl_i[2*i +: 2] == 2'b11) elegal = 1'b0;
        e1 = bsel(cfg_s1, bsrc(cfg_s1[1:0], line_i[1:0]), bsrc(cfg_s1[3:2], line_i[3:2]),
                  bsrc(cfg_s1[5:4], line_i[5:4]), ctl_i[1:0]);
        e3 = bsel(cfg_s3, bsrc(cfg_s3[1:0], line_i[13:12]), bsrc(cfg_s3[3:2], line_i[15:14]),
                  bsrc(cfg_s3[5:4], line_i[17:16]), ctl_i[5:4]);
        n2 = cfg_ext[4] ? bsrc(cfg_s2[1:0], line_i[7:6]) : e1;
        p2 = cfg_ext[5] ? bsrc(cfg_s2[5:4], line_i[11:10]) : e3;
        if (cfg_ext[0]) e2 = (ctl_i[3:2] == 2'b01) ? e1 : m_held;
        else            e2 = bsel(cfg_s2, n2, bsrc(cfg_s2[3:2], line_i[9:8]), p2, ctl_i[3:2]);
        case (cfg_ext[7:6])
            2'b01:   eaux = e1;
            2'b10:   eaux = e2;
            2'b11:   eaux = e3;
            default: eaux = 2'b00;
        endcase
        evld = (cfg_ext[7:6] != 2'b00);
        if (!elegal) begin e1 = 0; e2 = 0; e3 = 0; eaux = 0; end
    endtask

    task automatic chk(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] c, input logic [7:0] x,
                         input logic [17:0] ln, input logic [5:0] ct);
        cfg_s1 = a; cfg_s2 = b; cfg_s3 = c; cfg_ext = x; line_i = ln; ctl_i = ct;
        #1;
        model();
        chk(tag, "res", {2'b00, res_o}, {2'b00, e3, e2, e1});
        chk(tag, "aux", {6'b0, aux_o}, {6'b0, eaux});
        chk(tag, "vld", {7'b0, aux_vld_o}, {7'b0, evld});
        if (res_o[1:0] == 2'b11 || res_o[3:2] == 2'b11 || res_o[5:4] == 2'b11 || aux_o == 2'b11)
            chk("R10", "bad code out", 8'h11, 8'h00);
        @(posedge clk);
        if (elegal && cfg_ext[0]) m_held = e2;
        @(negedge clk);
    endtask

    function automatic logic [1:0] rtrit();
        int r = $urandom % 20;
        if (r == 0) return 2'b11;
        case (r % 3)
            0: return 2'b00;
            1: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cfg_ext = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset latch value", {6'b0, res_o[3:2]}, 8'h00);
        chk("R9", "reset aux vld", {7'b0, aux_vld_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3: slot N=P const, O=routed, P=N const; sweep controls
        for (int t = 0; t < 3; t++)
            apply("R3", 8'b00_10_11_01, 8'h30, 8'h00, 8'h70, 18'h00004,
                  {4'b0, (t == 0) ? 2'b10 : (t == 1) ? 2'b00 : 2'b01});
        apply("R2", 8'b00_11_00_10, 8'h00, 8'h00, 8'h40, 18'h00000, 6'b000000);
        // R4: XXY, control O gives N slot, P gives P slot
        apply("R4", 8'b01_10_00_01, 8'h00, 8'h00, 8'h40, 18'h0, 6'b000000);
        apply("R4", 8'b01_10_00_01, 8'h00, 8'h00, 8'h40, 18'h0, 6'b000001);
        // R5: XYY and both bits, control O gives P slot
        apply("R5", 8'b10_10_00_01, 8'h00, 8'h00, 8'h40, 18'h0, 6'b000000);
        apply("R5", 8'b11_10_00_01, 8'h00, 8'h00, 8'h40, 18'h0, 6'b000010);
        apply("R5", 8'b11_10_00_01, 8'h00, 8'h00, 8'h40, 18'h0, 6'b000001);
        // R6: chaining on and off
        apply("R6", 8'h01, 8'b00_00_00_00, 8'b00_00_00_10, 8'h80, 18'h0, 6'b00_10_00);
        apply("R6", 8'h01, 8'b00_00_00_00, 8'b00_00_00_10, 8'h90, 18'h0, 6'b00_10_00);
        apply("R6", 8'h01, 8'b00_00_00_00, 8'b00_00_00_10, 8'h80, 18'h0, 6'b00_01_00);
        apply("R6", 8'h01, 8'b00_00_00_00, 8'b00_00_00_10, 8'hA0, 18'h0, 6'b00_01_00);
        // R7: AUX sources
        for (int s = 0; s < 4; s++)
            apply("R7", 8'h01, 8'h02, 8'h15, 8'({s[1:0], 6'b110000}), 18'h0, 6'b000000);
        // R8 R9: latch open then hold
        apply("R8", 8'h15, 8'h00, 8'h00, 8'h81, 18'h0, 6'b00_01_00);
        apply("R9", 8'h2A, 8'h00, 8'h00, 8'h81, 18'h0, 6'b00_00_00);
        apply("R9", 8'h2A, 8'h00, 8'h00, 8'h81, 18'h0, 6'b00_10_00);
        apply("R8", 8'h2A, 8'h00, 8'h00, 8'h81, 18'h0, 6'b00_01_00);
        // R1: illegal code masks outputs and freezes latch
        apply("R1", 8'h15, 8'h00, 8'h00, 8'h81, 18'h30000, 6'b00_01_00);
        apply("R1", 8'h15, 8'h00, 8'h00, 8'h81, 18'h0, 6'b00_00_00);
        apply("R1", 8'h15, 8'h3F, 8'h00, 8'h80, 18'h0, 6'b11_00_00);
        for (int i = 0; i < 400; i++) begin
            logic [17:0] ln;
            logic [5:0]  ct;
            for (int j = 0; j < 9; j++) ln[2*j +: 2] = rtrit();
            for (int j = 0; j < 3; j++) ct[2*j +: 2] = rtrit();
            apply("R10", 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), ln, ct);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule